// File: doc/BRIEF.md
# Indirect control register bank

This block is a small control register bank behind an indirect microprocessor port. Software first loads an address pointer. Later data writes and data reads then reach the register that the pointer selects. The bank holds three things: a fixed identification code, one configuration register, and a write-only location whose only purpose is to trigger a software reset.

The configuration register also controls one general-purpose pin, which can take one of two roles. In the control-output role the bank drives the pin with a level that software programs. In the sense role the bank turns its output driver off and reports the pin level through a status register. The pin is held low during reset and while the system runs in VGA pass-through mode.

Top module: `ctlreg_bank`

## Requirements
- R1: A read at address 0x3F returns 0x10 every time, whatever the configuration, the pass-through input and the pin input are.
- R2: After the pointer is loaded with 0x1A, a data write stores all eight bits in the configuration register, and a read at 0x1A returns them unchanged.
- R3: A data write of any value while the pointer holds 0xFF returns the configuration register to 0x00 from the next cycle on. The pointer keeps its value, and a read at 0xFF returns 0x00.
- R4: While `rst` is high, `pin_out` is 0 and `pin_oe` is 1. The first cycle after the reset edge finds the configuration at 0x00, the pointer at 0x00 and `rdata` at 0x00.
- R5: When configuration bit 3 is 0 (control-output role) and pass-through is off, `pin_oe` is 1 and `pin_out` equals configuration bit 2.
- R6: While `passthru` is 1, `pin_out` is 0, whatever configuration bit 2 holds.
- R7: When configuration bit 3 is 1 (sense role), `pin_oe` and `pin_out` are both 0. A read at 0x1B then returns the pin input in bit 0, delayed by a two-stage synchronizer, with bits 7:1 at 0. In the control-output role a read at 0x1B returns 0x00.
- R8: A read at an address other than 0x1A, 0x1B and 0x3F returns 0x00. A data write to any address other than 0x1A and 0xFF leaves the configuration register unchanged.
- R9: `rdata` is registered. It takes the selected value at the clock edge where `rd_en` is high and keeps its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ptr_we | input | 1 | Loads `wdata` into the address pointer |
| data_we | input | 1 | Writes `wdata` to the register at the pointer |
| rd_en | input | 1 | Captures the register at the pointer into `rdata` |
| wdata | input | 8 | Write data for the pointer or a register |
| rdata | output | 8 | Registered read data |
| passthru | input | 1 | VGA pass-through mode is active |
| pin_in | input | 1 | Level sensed on the multipurpose pin |
| pin_out | output | 1 | Level driven onto the multipurpose pin |
| pin_oe | output | 1 | Output enable for the pin driver |

## Verification
Pointer loads and configuration writes take effect at the strobe edge, so the first read issued after them already sees the new value. A read shows up on `rdata` one edge after `rd_en`, and the bench samples it on the falling edge that follows. `pin_out` and `pin_oe` are combinational from the configuration, the pass-through input and reset, so the bench checks them on the falling edge right after a change. A change on `pin_in` needs two edges to pass the synchronizer plus one more edge for the read, so the bench holds a new pin level for three cycles before it reads status.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [AW-1:0] ADDR_CFG  = 8'h1A;
    localparam logic [AW-1:0] ADDR_STAT = 8'h1B;
    localparam logic [AW-1:0] ADDR_ID   = 8'h3F;
    localparam logic [AW-1:0] ADDR_SRST = 8'hFF;

    localparam logic [DW-1:0] ID_CODE = 8'h10;

    typedef struct packed {
        logic [3:0] spare_hi;
        logic       sense_role;
        logic       drive_level;
        logic [1:0] spare_lo;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '0;

    function automatic logic [DW-1:0] reg_read(input logic [AW-1:0] addr,
                                               input cfg_t cfg,
                                               input logic sense_sync);
        logic [DW-1:0] v;
        case (addr)
            ADDR_CFG:  v = cfg;
            ADDR_STAT: v = {{(DW-1){1'b0}}, cfg.sense_role & sense_sync};
            ADDR_ID:   v = ID_CODE;
            default:   v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/ctlreg_port.sv
module ctlreg_port
    import ctlreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ptr_we,
    input  logic          data_we,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] ptr,
    output logic          cfg_we,
    output logic          srst_we
);
    always_ff @(posedge clk) begin
        if (rst)         ptr <= '0;
        else if (ptr_we) ptr <= wdata[AW-1:0];
    end

    assign cfg_we  = data_we && (ptr == ADDR_CFG);
    assign srst_we = data_we && (ptr == ADDR_SRST);

    // R3: the software reset location leaves the pointer where it was
    a_r3_ptr_kept: assert property (@(posedge clk) disable iff (rst)
        srst_we && !ptr_we |=> ptr == ADDR_SRST);
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
    import ctlreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          srst_we,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst || srst_we) cfg <= CFG_DEFAULT;
        else if (cfg_we)    cfg <= cfg_t'(wdata);
    end

    a_r2_cfg_write: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg == $past(wdata));
    a_r3_soft_reset: assert property (@(posedge clk) disable iff (rst)
        srst_we |=> cfg == CFG_DEFAULT);
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_we && !srst_we |=> $stable(cfg));
endmodule

// File: rtl/ctlreg_pin.sv
module ctlreg_pin
    import ctlreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  logic passthru,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic sense_sync
);
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin_in;
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign sense_sync = chain[SYNC_STAGES-1];
    assign pin_oe     = rst | ~cfg.sense_role;
    assign pin_out    = ~rst & ~passthru & ~cfg.sense_role & cfg.drive_level;

    // R6: pass-through forces the pin low
    a_r6_passthru_low: assert property (@(posedge clk) disable iff (rst)
        passthru |-> !pin_out);
    // R7: no drive in sense role
    a_r7_sense_off: assert property (@(posedge clk) disable iff (rst)
        cfg.sense_role |-> !pin_oe && !pin_out);
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ptr_we,
    input  logic          data_we,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          passthru,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe
);
    logic [AW-1:0] ptr;
    logic          cfg_we;
    logic          srst_we;
    cfg_t          cfg;
    logic          sense_sync;

    ctlreg_port i_port (
        .clk(clk), .rst(rst), .ptr_we(ptr_we), .data_we(data_we),
        .wdata(wdata), .ptr(ptr), .cfg_we(cfg_we), .srst_we(srst_we)
    );

    ctlreg_store i_store (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .srst_we(srst_we),
        .wdata(wdata), .cfg(cfg)
    );

    ctlreg_pin #(.SYNC_STAGES(2)) i_pin (
        .clk(clk), .rst(rst), .cfg(cfg), .passthru(passthru),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .sense_sync(sense_sync)
    );

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= reg_read(ptr, cfg, sense_sync);
    end

    a_r1_id_const: assert property (@(posedge clk) disable iff (rst)
        rd_en && ptr == ADDR_ID |=> rdata == ID_CODE);
    a_r3_srst_reads_zero: assert property (@(posedge clk) disable iff (rst)
        rd_en && ptr == ADDR_SRST |=> rdata == '0);
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_ctlreg_bank.sv
module test_ctlreg_bank;
    logic       clk = 0;
    logic       rst = 1;
    logic       ptr_we = 0, data_we = 0, rd_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       passthru = 0, pin_in = 0;
    logic       pin_out, pin_oe;

    int checks = 0, errors = 0;
    logic [7:0] m_cfg = 0, m_ptr = 0;
    logic       done = 0;

    always #5 clk = ~clk;

    ctlreg_bank i_ctlreg_bank (
        .clk(clk), .rst(rst), .ptr_we(ptr_we), .data_we(data_we),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .passthru(passthru),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] c,
                                            input logic p);
        if (a == 8'h1A) return c;
        if (a == 8'h1B) return {7'b0, c[3] & p};
        if (a == 8'h3F) return 8'h10;
        return 8'h00;
    endfunction

    function automatic logic exp_pin(input logic [7:0] c, input logic pt);
        return !c[3] && !pt && c[2];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [7:0] a);
        @(negedge clk); ptr_we = 1; wdata = a;
        @(negedge clk); ptr_we = 0;
        m_ptr = a;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); data_we = 1; wdata = d;
        @(negedge clk); data_we = 0;
        if (m_ptr == 8'h1A) m_cfg = d;
        else if (m_ptr == 8'hFF) m_cfg = 8'h00;
    endtask

    task automatic rd_chk(input string req);
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
        chk(req, rdata, exp_read(m_ptr, m_cfg, pin_in));
    endtask

    task automatic pin_chk(input string req);
        chk(req, {6'b0, pin_oe, pin_out}, {6'b0, !m_cfg[3], exp_pin(m_cfg, passthru)});
    endtask

    task automatic set_pin_in(input logic v);
        @(negedge clk); pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R4 pin during reset", {6'b0, pin_oe, pin_out}, 8'h02);
        rst = 0;
        @(negedge clk);
        chk("R4 rdata after reset", rdata, 8'h00);
        rd_chk("R4 pointer 0 reads 0");
        pin_chk("R4 pin after reset");

        set_ptr(8'h3F); rd_chk("R1 id read");
        set_ptr(8'h1A); wr(8'hA5); rd_chk("R2 cfg readback");
        wr(8'h04); rd_chk("R2 cfg write 04"); pin_chk("R5 drive high");
        passthru = 1; @(negedge clk); pin_chk("R6 passthru low");
        set_ptr(8'h3F); rd_chk("R1 id during passthru");
        passthru = 0; @(negedge clk); pin_chk("R5 drive restored");

        set_ptr(8'hFF); wr(8'h5C);
        rd_chk("R3 reset location reads 0");
        chk("R3 pointer kept", rdata, 8'h00);
        set_ptr(8'h1A); rd_chk("R3 cfg cleared by soft reset");
        pin_chk("R3 pin after soft reset");

        wr(8'h0C); pin_chk("R7 sense role no drive");
        set_ptr(8'h1B);
        set_pin_in(1); rd_chk("R7 sense high");
        set_pin_in(0); rd_chk("R7 sense low");
        set_pin_in(1);
        set_ptr(8'h1A); wr(8'h04);
        set_ptr(8'h1B); rd_chk("R7 status zero in control role");

        set_ptr(8'h3F); wr(8'hEE);
        set_ptr(8'h1A); rd_chk("R8 id write ignored");
        set_ptr(8'h55); wr(8'h99); rd_chk("R8 unmapped reads 0");
        set_ptr(8'h1A); rd_chk("R8 unmapped write ignored");

        held = rdata;
        wr(8'h33);
        repeat (3) @(negedge clk);
        chk("R9 rdata holds without rd_en", rdata, held);

        rst = 1; @(negedge clk);
        chk("R4 pin low in reset", {6'b0, pin_oe, pin_out}, 8'h02);
        rst = 0; m_cfg = 0; m_ptr = 0; @(negedge clk);
        set_ptr(8'h1A); rd_chk("R4 cfg default after power reset");

        for (int i = 0; i < 300; i++) begin
            int op;
            logic [7:0] a;
            op = $urandom_range(0, 3);
            case ($urandom_range(0, 4))
                0: a = 8'h1A;
                1: a = 8'h1B;
                2: a = 8'h3F;
                3: a = 8'hFF;
                default: a = 8'($urandom);
            endcase
            set_ptr(a);
            if (op == 0) wr(8'($urandom));
            else if (op == 1) set_pin_in(1'($urandom));
            else if (op == 2) begin passthru = 1'($urandom); @(negedge clk); end
            rd_chk("R8 random read");
            pin_chk("R5 random pin");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule